// File: doc/BRIEF.md
# Instruction Line Alignment Buffer

This block sits between instruction fetch and dispatch. Fetch delivers 128-bit memory lines of four 32-bit words through a valid/ready handshake. Code is packed in memory with no alignment, so an instruction group may begin at any word and continue into the next line. The buffer holds up to five fetched lines and rebuilds the word stream into execution groups of one to four instructions. Each group starts at output slot 0, and a per-slot mask marks which slots belong to it.

Bit 31 of each word marks the last instruction of its group. Dispatch takes the presented group with a consume strobe, and the buffer then moves its read position forward by the length of that group. A flush input drops everything held in the buffer when the program is redirected.

Top module: `insn_align_buf`

## Requirements
- R1: After reset, out_valid_o is 0, out_mask_o is 0 and fetch_ready_o is 1.
- R2: fetch_ready_o is 0 exactly when five lines are held. A line stays held until all four of its words have been consumed. A line offered while fetch_ready_o is 0 is dropped.
- R3: In a fetched line, word i sits in bits [32i+31:32i], and lower i means earlier in program order. Accepted lines keep their arrival order.
- R4: A group ends at its first word whose bit 31 is 1, and a group is never longer than four words. If four words are present and none of them is marked, those four words form the group.
- R5: out_valid_o is 1 only when every word of the group, through its end word, is in the buffer. A group may span two fetched lines.
- R6: Output slot j (bits [32j+31:32j]) carries the j-th word of the group. out_mask_o bit j is 1 exactly for the slots of the group, starting at slot 0 with no gaps. Slots outside the group read 0. Mask and data are both 0 while out_valid_o is 0.
- R7: If out_consume_i is 1 while out_valid_o is 1, the next group appears after that clock edge. If out_consume_i is 1 while out_valid_o is 0, it has no effect.
- R8: flush_i empties the buffer and clears the read position at the same edge. A line offered in the flush cycle is dropped.
- R9: A line accepted at a clock edge is visible at the outputs right after that edge. The outputs are combinational from the buffer state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the buffer |
| fetch_valid_i | input | 1 | Fetched line offered |
| fetch_ready_o | output | 1 | Buffer can accept a line |
| fetch_line_i | input | 128 | Fetched line, four words |
| out_valid_o | output | 1 | A complete group is presented |
| out_mask_o | output | 4 | Slots holding the group |
| out_data_o | output | 128 | Group, first word in slot 0 |
| out_consume_i | input | 1 | Dispatch takes the group |

## Verification
Every state change takes effect at the clock edge that samples the stimulus. An accepted line, a consumed group or a flush therefore shows on the outputs one edge later, and the outputs are combinational from the state. The bench sets its inputs on the falling edge and updates its word-queue model right after the rising edge. It compares valid, mask, data and ready on the next falling edge, so each result is checked in the cycle it is due. Directed cases cover a full buffer, a group that spans two lines, a consume while nothing is valid, and a flush that coincides with a fetch.

// File: rtl/iab_pkg.sv
package iab_pkg;
  localparam int unsigned IAB_DEPTH  = 5;
  localparam int unsigned IAB_SLOTS  = 4;
  localparam int unsigned IAB_WORD_W = 32;
endpackage

// File: rtl/iab_line_store.sv
module iab_line_store #(
  parameter int unsigned DEPTH  = 5,
  parameter int unsigned LINE_W = 128,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [LINE_W-1:0] wr_line_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [IDX_W-1:0]  rd_nxt_idx_i,
  output logic [LINE_W-1:0] rd_line_o,
  output logic [LINE_W-1:0] rd_nxt_o
);
  logic [LINE_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   mem_q[g] <= '0;
      else if (wr_en_i && wr_idx_i == IDX_W'(g))     mem_q[g] <= wr_line_i;
    end
  end

  assign rd_line_o = mem_q[rd_idx_i];
  assign rd_nxt_o  = mem_q[rd_nxt_idx_i];
endmodule

// File: rtl/iab_ptr_ctrl.sv
module iab_ptr_ctrl #(
  parameter int unsigned DEPTH = 5,
  parameter int unsigned SLOTS = 4,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned LEN_W = $clog2(SLOTS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic             adv_i,
  input  logic [LEN_W-1:0] adv_len_i,
  output logic [IDX_W-1:0] head_o,
  output logic [IDX_W-1:0] nxt_o,
  output logic [IDX_W-1:0] tail_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [OFF_W-1:0] off_o,
  output logic             full_o
);
  localparam int unsigned SUM_W = LEN_W + 1;

  function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(DEPTH - 1)) ? '0 : i + IDX_W'(1);
  endfunction

  logic [IDX_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] cnt_q;
  logic [OFF_W-1:0] off_q;
  logic [SUM_W-1:0] sum;
  logic             pop;

  // read slot plus group length; a group never crosses more than one line
  assign sum = SUM_W'(off_q) + SUM_W'(adv_len_i);
  assign pop = adv_i && (sum >= SUM_W'(SLOTS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
    end else if (flush_i) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      off_q  <= '0;
    end else begin
      if (push_i) tail_q <= wrap_inc(tail_q);
      if (pop)    head_q <= wrap_inc(head_q);
      if (adv_i)  off_q  <= pop ? OFF_W'(sum - SUM_W'(SLOTS)) : OFF_W'(sum);
      case ({push_i, pop})
        2'b10:   cnt_q <= cnt_q + CNT_W'(1);
        2'b01:   cnt_q <= cnt_q - CNT_W'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign head_o = head_q;
  assign nxt_o  = wrap_inc(head_q);
  assign tail_o = tail_q;
  assign cnt_o  = cnt_q;
  assign off_o  = off_q;
  assign full_o = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/iab_group_find.sv
module iab_group_find #(
  parameter int unsigned DEPTH   = 5,
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned END_BIT = 31,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1),
  localparam int unsigned OFF_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int unsigned LEN_W  = $clog2(SLOTS + 1),
  localparam int unsigned LINE_W = SLOTS * WORD_W
) (
  input  logic [2*LINE_W-1:0] win_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [CNT_W-1:0]    cnt_i,
  output logic                valid_o,
  output logic [SLOTS-1:0]    mask_o,
  output logic [LINE_W-1:0]   data_o,
  output logic [LEN_W-1:0]    len_o
);
  always_comb begin
    logic            done;
    logic [WORD_W-1:0] w;
    int              idx;
    int              avail;
    done    = 1'b0;
    valid_o = 1'b0;
    mask_o  = '0;
    data_o  = '0;
    len_o   = '0;
    avail   = int'(cnt_i) * int'(SLOTS);
    for (int i = 0; i < int'(SLOTS); i++) begin
      idx = int'(off_i) + i;
      w   = win_i[idx*WORD_W +: WORD_W];
      if (!done) begin
        if (idx < avail) begin
          mask_o[i]                 = 1'b1;
          data_o[i*WORD_W +: WORD_W] = w;
          if (w[END_BIT]) begin
            done    = 1'b1;
            valid_o = 1'b1;
            len_o   = LEN_W'(i + 1);
          end else if (i == int'(SLOTS) - 1) begin
            valid_o = 1'b1;         // unmarked four-word run is capped
            len_o   = LEN_W'(SLOTS);
          end
        end else begin
          done = 1'b1;
        end
      end
    end
    if (!valid_o) begin
      mask_o = '0;
      data_o = '0;
      len_o  = '0;
    end
  end
endmodule

// File: rtl/insn_align_buf.sv
module insn_align_buf
  import iab_pkg::*;
#(
  parameter int unsigned DEPTH   = IAB_DEPTH,
  parameter int unsigned SLOTS   = IAB_SLOTS,
  parameter int unsigned WORD_W  = IAB_WORD_W,
  parameter int unsigned END_BIT = WORD_W - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    fetch_valid_i,
  output logic                    fetch_ready_o,
  input  logic [SLOTS*WORD_W-1:0] fetch_line_i,
  output logic                    out_valid_o,
  output logic [SLOTS-1:0]        out_mask_o,
  output logic [SLOTS*WORD_W-1:0] out_data_o,
  input  logic                    out_consume_i
);
  localparam int unsigned LINE_W = SLOTS * WORD_W;
  localparam int unsigned IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1);
  localparam int unsigned OFF_W  = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int unsigned LEN_W  = $clog2(SLOTS + 1);

  logic [IDX_W-1:0]  head_idx, nxt_idx, tail_idx;
  logic [CNT_W-1:0]  line_cnt;
  logic [OFF_W-1:0]  rd_off;
  logic              full;
  logic              push, adv;
  logic [LEN_W-1:0]  grp_len;
  logic [LINE_W-1:0] head_line, nxt_line;

  assign fetch_ready_o = !full;
  assign push          = fetch_valid_i && fetch_ready_o && !flush_i;
  assign adv           = out_valid_o && out_consume_i && !flush_i;

  iab_line_store #(.DEPTH(DEPTH), .LINE_W(LINE_W)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (push),
    .wr_idx_i    (tail_idx),
    .wr_line_i   (fetch_line_i),
    .rd_idx_i    (head_idx),
    .rd_nxt_idx_i(nxt_idx),
    .rd_line_o   (head_line),
    .rd_nxt_o    (nxt_line)
  );

  iab_ptr_ctrl #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush_i),
    .push_i   (push),
    .adv_i    (adv),
    .adv_len_i(grp_len),
    .head_o   (head_idx),
    .nxt_o    (nxt_idx),
    .tail_o   (tail_idx),
    .cnt_o    (line_cnt),
    .off_o    (rd_off),
    .full_o   (full)
  );

  iab_group_find #(
    .DEPTH(DEPTH), .SLOTS(SLOTS), .WORD_W(WORD_W), .END_BIT(END_BIT)
  ) u_find (
    .win_i  ({nxt_line, head_line}),
    .off_i  (rd_off),
    .cnt_i  (line_cnt),
    .valid_o(out_valid_o),
    .mask_o (out_mask_o),
    .data_o (out_data_o),
    .len_o  (grp_len)
  );
endmodule

// File: rtl/iab_chk.sv
module iab_chk #(
  parameter int unsigned DEPTH   = 5,
  parameter int unsigned SLOTS   = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned END_BIT = 31,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    flush_i,
  input logic                    fetch_valid_i,
  input logic                    fetch_ready_o,
  input logic                    out_valid_o,
  input logic [SLOTS-1:0]        out_mask_o,
  input logic [SLOTS*WORD_W-1:0] out_data_o,
  input logic                    out_consume_i,
  input logic [CNT_W-1:0]        line_cnt
);
  logic idle;
  assign idle = !flush_i && !(fetch_valid_i && fetch_ready_o) && !(out_valid_o && out_consume_i);

  assert_cnt_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_cnt <= CNT_W'(DEPTH));

  assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fetch_ready_o && !flush_i && !out_consume_i) |=> !fetch_ready_o);

  assert_mask_shape_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_mask_o[0] && ((out_mask_o + SLOTS'(1)) & out_mask_o) == '0));

  assert_mask_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> (out_mask_o == '0 && out_data_o == '0));

  assert_single_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_mask_o == SLOTS'(1)) |-> out_data_o[END_BIT]);

  assert_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (!out_valid_o && fetch_ready_o));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle |=> ($stable(out_valid_o) && $stable(out_mask_o) && $stable(out_data_o)));
endmodule

bind insn_align_buf iab_chk #(
  .DEPTH(DEPTH), .SLOTS(SLOTS), .WORD_W(WORD_W), .END_BIT(END_BIT)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .fetch_valid_i(fetch_valid_i),
  .fetch_ready_o(fetch_ready_o),
  .out_valid_o  (out_valid_o),
  .out_mask_o   (out_mask_o),
  .out_data_o   (out_data_o),
  .out_consume_i(out_consume_i),
  .line_cnt     (line_cnt)
);

// File: tb/sim_insn_align_buf.sv
`timescale 1ns/1ps
module sim_insn_align_buf;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         flush_i = 1'b0;
  logic         fetch_valid_i = 1'b0;
  logic         fetch_ready_o;
  logic [127:0] fetch_line_i = '0;
  logic         out_valid_o;
  logic [3:0]   out_mask_o;
  logic [127:0] out_data_o;
  logic         out_consume_i = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] wq[$];
  int          lines = 0;
  int          off = 0;

  always #2 clk_i = ~clk_i;

  insn_align_buf u0 (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model_out(output logic v, output logic [3:0] m,
                                    output logic [127:0] d, output int len);
    int n;
    v = 1'b0; m = '0; d = '0; len = 0;
    n = (wq.size() < 4) ? wq.size() : 4;
    for (int i = 0; i < n; i++) begin
      m[i] = 1'b1;
      d[i*32 +: 32] = wq[i];
      if (wq[i][31]) begin v = 1'b1; len = i + 1; break; end
      if (i == 3) begin v = 1'b1; len = 4; end
    end
    if (!v) begin m = '0; d = '0; end
  endfunction

  function automatic logic [31:0] rnd_word();
    logic [31:0] w;
    w = $urandom & 32'h7fff_ffff;
    if ($urandom % 3 == 0) w[31] = 1'b1;
    return w;
  endfunction

  function automatic logic [127:0] rnd_line();
    logic [127:0] l;
    for (int i = 0; i < 4; i++) l[i*32 +: 32] = rnd_word();
    return l;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic cyc(input logic fv, input logic [127:0] ln, input logic cons, input logic fl);
    logic ev; logic [3:0] em; logic [127:0] ed; int len; logic rdy;
    model_out(ev, em, ed, len);
    rdy = (lines < 5);
    chk("R2 ready", {127'd0, fetch_ready_o}, {127'd0, rdy});
    chk("R5 valid", {127'd0, out_valid_o}, {127'd0, ev});
    chk("R6 mask", {124'd0, out_mask_o}, {124'd0, em});
    chk("R4 data", out_data_o, ed);
    fetch_valid_i = fv; fetch_line_i = ln; out_consume_i = cons; flush_i = fl;
    @(posedge clk_i);
    if (fl) begin
      wq.delete(); lines = 0; off = 0;
    end else begin
      if (ev && cons) begin
        for (int i = 0; i < len; i++) void'(wq.pop_front());
        off += len;
        if (off >= 4) begin lines--; off -= 4; end
      end
      if (fv && rdy) begin
        for (int i = 0; i < 4; i++) wq.push_back(ln[i*32 +: 32]);
        lines++;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [127:0] l;
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset valid", {127'd0, out_valid_o}, 128'd0);
    chk("R1 reset mask", {124'd0, out_mask_o}, 128'd0);
    chk("R1 reset ready", {127'd0, fetch_ready_o}, 128'd1);

    // order and first slot
    l = {32'h8000_0004, 32'h8000_0003, 32'h0000_0002, 32'h8000_0001};
    cyc(1, l, 0, 0);
    chk("R3 slot0 word0", out_data_o, {96'd0, 32'h8000_0001});
    chk("R9 visible next edge", {127'd0, out_valid_o}, 128'd1);
    cyc(0, '0, 1, 0);
    chk("R3 second group", out_data_o, {64'd0, 32'h8000_0003, 32'h0000_0002});
    chk("R7 advance mask", {124'd0, out_mask_o}, 128'h3);
    cyc(0, '0, 1, 0);
    cyc(0, '0, 1, 0);
    chk("R7 drained", {127'd0, out_valid_o}, 128'd0);
    cyc(0, '0, 1, 0);  // consume while not valid
    chk("R7 ignored consume", {127'd0, out_valid_o}, 128'd0);
    chk("R7 ignored ready", {127'd0, fetch_ready_o}, 128'd1);

    // span across lines
    cyc(1, {32'h0000_0013, 32'h0000_0012, 32'h0000_0011, 32'h8000_0010}, 0, 0);
    cyc(0, '0, 1, 0);
    chk("R5 partial not valid", {127'd0, out_valid_o}, 128'd0);
    cyc(1, {32'h8000_0023, 32'h8000_0022, 32'h0000_0021, 32'h8000_0020}, 0, 0);
    chk("R5 span data", out_data_o, {32'h8000_0020, 32'h0000_0013, 32'h0000_0012, 32'h0000_0011});
    chk("R5 span mask", {124'd0, out_mask_o}, 128'hf);

    // full buffer, unmarked cap
    cyc(0, '0, 0, 1);
    for (int k = 0; k < 5; k++) cyc(1, {4{32'h0000_0a00 + k}}, 0, 0);
    chk("R2 full ready low", {127'd0, fetch_ready_o}, 128'd0);
    cyc(1, {4{32'h8000_0bad}}, 0, 0);
    chk("R2 dropped line", out_data_o, {4{32'h0000_0a00}});
    chk("R4 cap mask", {124'd0, out_mask_o}, 128'hf);
    cyc(0, '0, 1, 0);
    chk("R2 ready after pop", {127'd0, fetch_ready_o}, 128'd1);

    // flush with simultaneous fetch
    cyc(1, {4{32'h8000_0ccc}}, 1, 1);
    chk("R8 flushed valid", {127'd0, out_valid_o}, 128'd0);
    chk("R8 flushed ready", {127'd0, fetch_ready_o}, 128'd1);
    cyc(1, {32'h0, 32'h0, 32'h8000_0d01, 32'h0000_0d00}, 0, 0);
    chk("R8 fresh after flush", out_data_o, {64'd0, 32'h8000_0d01, 32'h0000_0d00});

    // constrained random
    for (int k = 0; k < 4000; k++)
      cyc(($urandom % 4) != 0, rnd_line(), ($urandom % 3) != 0, ($urandom % 64) == 0);

    fetch_valid_i = 0; out_consume_i = 0; flush_i = 0;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule